// File: doc/BRIEF.md
# Six-Channel Multi-Mode 16-bit Timer Bank

The bank holds six 16-bit timer channels, arranged as two rings of three. Every channel owns one counter and one reload register. A per-channel mode register chooses between three behaviours that share one datapath:

- **Interval timing:** the counter counts down on a selected prescaled tick and reloads when it passes zero.
- **Event counting:** the counter counts down on edges of an external pin, or on underflows of a neighbouring channel.
- **Interval measurement:** the counter counts up and is cleared by pin edges. Each completed count is captured into the reload register so that software can read it back.

Software reaches the bank through a byte-wide register port. The port has a write strobe, an address and write data. Read data is combinational from the address. The port has no valid/ready handshake and never back-pressures: every write strobe is accepted in the cycle it is presented.

The prescaled ticks come from outside the bank. They arrive as single-cycle enables, and the bank does not generate them.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every counter, reload register, mode register and the start register read as zero, and `underflow` is all zero.
- R2: While a channel's start bit is 0, a write to a reload byte (offset 0 low, offset 1 high, at channel base c*8) also writes the same byte of the counter. The counter is read at offsets 2 (low) and 3 (high).
- R3: In interval mode (mode bits [1:0]=00), a running counter decrements by one on each cycle where the tick chosen by clock-select bits [3:2] is high. The encoding is 00 fast, 01 divide-by-8, 10 divide-by-32, 11 slow. Ticks that are not selected have no effect.
- R4: When a running down-counter at zero receives a count event, it loads the reload value. In the next cycle it raises its `underflow` bit for exactly one cycle.
- R5: A reload write while the channel runs leaves the counter unchanged. The new value is loaded at the next underflow.
- R6: In event mode (mode=01, clock-select bit 3 = 0), the counter decrements on the rising edge of its `ext_in` bit when the edge bit (bit 4) is 0, and on the falling edge when bit 4 is 1. The other edge has no effect.
- R7: In event mode with clock-select bit 3 = 1, channel i counts underflows of channel i-1. The exceptions are channel 0, which counts channel 2, and channel 3, which counts channel 5. Underflows from channels outside that mapping have no effect.
- R8: In measurement mode (mode=10) with bit 4 = 0, the counter increments on the selected tick. Each rising edge of `ext_in` copies the count into the reload register and clears the counter, so an edge-to-edge spacing of P cycles with the tick held high captures P-1.
- R9: In measurement mode with bit 4 = 1, a rising edge clears the counter. A falling edge copies the count into the reload register and clears the counter, so a high time of H cycles captures H-1.
- R10: In measurement mode, a counter wrap from 0xFFFF sets a sticky overflow flag, read as bit 5 of the mode register (offset 4). Any write to that mode register clears the flag.
- R11: While a channel's start bit is 0 (start register at address 48, bit c for channel c), its counter holds its value.
- R12: A channel with mode 11 holds its counter even while started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Undivided count enable |
| tick_div8 | input | 1 | Divide-by-8 count enable |
| tick_div32 | input | 1 | Divide-by-32 count enable |
| tick_slow | input | 1 | Low-speed count enable |
| ext_in | input | 6 | Per-channel external pin, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for addr |
| underflow | output | 6 | One-cycle underflow pulse per channel |

## Verification
The assertions take two things for granted about the inputs:

- `ext_in` is already synchronous to `clk`.
- `ext_in` is low when reset is released, so no spurious edge is seen at start-up.

Counter-hold properties apply only in cycles without a register write, because a write may legally alter a stopped counter. The stimulus follows these rules:

- It drives every input just after the falling clock edge.
- It raises each pin and tick for whole cycles only.
- It keeps ticks low while it issues writes whose effect on the counters it checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 16;
  localparam int REG_STRIDE = 8;

  typedef enum logic [1:0] {
    MD_INTERVAL = 2'b00,
    MD_EVENT    = 2'b01,
    MD_MEASURE  = 2'b10,
    MD_IDLE     = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  tmr_mode_e    mode,
  input  logic [1:0]   clk_sel,
  input  logic         edge_sel,
  input  logic [3:0]   ticks,
  input  logic         ext,
  input  logic         casc_in,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic         mode_wr,
  input  logic [7:0]   wbyte,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reload,
  output logic         uf,
  output logic         ovf
);
  logic rise, fall, tick_sel, ev, count_en, capture, restart;

  tmr_edge u_edge (.clk(clk), .rst_n(rst_n), .sig(ext), .rise(rise), .fall(fall));

  assign tick_sel = ticks[clk_sel];
  assign ev       = edge_sel ? fall : rise;

  always_comb begin
    count_en = 1'b0;
    unique case (mode)
      MD_INTERVAL: count_en = tick_sel;
      MD_EVENT:    count_en = clk_sel[1] ? casc_in : ev;
      default:     count_en = 1'b0;
    endcase
  end

  // measurement: period closes on rise; width opens on rise, closes on fall
  assign capture = edge_sel ? fall : rise;
  assign restart = edge_sel & rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
      uf     <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      uf <= 1'b0;
      if (mode_wr) ovf <= 1'b0;
      if (ld_lo) begin
        reload[7:0] <= wbyte;
        if (!run) cnt[7:0] <= wbyte;
      end
      if (ld_hi) begin
        reload[W-1:8] <= wbyte;
        if (!run) cnt[W-1:8] <= wbyte;
      end
      if (run) begin
        if (mode == MD_MEASURE) begin
          if (capture) begin
            reload <= cnt;
            cnt    <= '0;
          end else if (restart) begin
            cnt <= '0;
          end else if (tick_sel) begin
            cnt <= cnt + 1'b1;
            if (&cnt) ovf <= 1'b1;
          end
        end else if (count_en) begin
          if (cnt == '0) begin
            cnt <= reload;
            uf  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_GRP  = 2,
  parameter int GRP_SZ = 3,
  localparam int NCH   = N_GRP * GRP_SZ,
  localparam int AW    = $clog2(NCH * REG_STRIDE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_fast,
  input  logic           tick_div8,
  input  logic           tick_div32,
  input  logic           tick_slow,
  input  logic [NCH-1:0] ext_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rd_data,
  output logic [NCH-1:0] underflow
);
  localparam logic [AW-1:0] START_ADDR = AW'(NCH * REG_STRIDE);

  logic [NCH-1:0]       start_q;
  logic [4:0]           mode_q [NCH];
  logic [CNT_W-1:0]     cnt_a  [NCH];
  logic [CNT_W-1:0]     rl_a   [NCH];
  logic [NCH-1:0]       ovf_a;
  logic [NCH*CNT_W-1:0] cnt_all;
  logic [2*NCH-1:0]     mode_all;
  logic [3:0]           ticks;

  assign ticks = {tick_slow, tick_div32, tick_div8, tick_fast};

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (wr_en && addr == START_ADDR) start_q <= wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int SRC = (i % GRP_SZ == 0) ? i + GRP_SZ - 1 : i - 1;
    localparam logic [AW-1:0] BASE = AW'(i * REG_STRIDE);
    logic mode_wr;

    assign mode_wr = wr_en && addr == BASE + AW'(4);

    always_ff @(posedge clk) begin
      if (!rst_n)       mode_q[i] <= '0;
      else if (mode_wr) mode_q[i] <= wdata[4:0];
    end

    tmr_chan #(.W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (start_q[i]),
      .mode    (tmr_mode_e'(mode_q[i][1:0])),
      .clk_sel (mode_q[i][3:2]),
      .edge_sel(mode_q[i][4]),
      .ticks   (ticks),
      .ext     (ext_in[i]),
      .casc_in (underflow[SRC]),
      .ld_lo   (wr_en && addr == BASE),
      .ld_hi   (wr_en && addr == BASE + AW'(1)),
      .mode_wr (mode_wr),
      .wbyte   (wdata),
      .cnt     (cnt_a[i]),
      .reload  (rl_a[i]),
      .uf      (underflow[i]),
      .ovf     (ovf_a[i])
    );

    assign cnt_all[i*CNT_W +: CNT_W] = cnt_a[i];
    assign mode_all[2*i +: 2]        = mode_q[i][1:0];
  end

  always_comb begin
    int ch;
    ch = int'(addr) / REG_STRIDE;
    rd_data = '0;
    if (addr == START_ADDR) begin
      rd_data[NCH-1:0] = start_q;
    end else if (ch < NCH) begin
      unique case (addr[2:0])
        3'd0:    rd_data = rl_a[ch][7:0];
        3'd1:    rd_data = rl_a[ch][CNT_W-1:8];
        3'd2:    rd_data = cnt_a[ch][7:0];
        3'd3:    rd_data = cnt_a[ch][CNT_W-1:8];
        3'd4:    rd_data = {2'b00, ovf_a[ch], mode_q[ch]};
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NCH = 6,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [NCH-1:0] underflow,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] ovf,
  input logic [NCH*CW-1:0] cnt_all,
  input logic [2*NCH-1:0]  mode_all
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R4
    uf_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow[i] |-> $past(cnt_all[i*CW +: CW]) == '0);

    // R4
    uf_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow[i] |-> $past(start[i]));

    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start[i] && !wr_en) |=> $stable(cnt_all[i*CW +: CW]));

    // R12
    idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[2*i +: 2] == 2'b11 && !wr_en) |=> $stable(cnt_all[i*CW +: CW]));

    // R10
    ovf_in_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[i]) |-> $past(mode_all[2*i +: 2]) == 2'b10);
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CW(tmr_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .underflow(underflow),
  .start(start_q), .ovf(ovf_a), .cnt_all(cnt_all), .mode_all(mode_all)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam int CLK_P = 10;
  localparam logic [5:0] START_A = 6'd48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_fast = 0, tick_div8 = 0, tick_div32 = 0, tick_slow = 0;
  logic [5:0] ext_in = '0;
  logic wr_en = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [5:0] underflow;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_bank u0 (.*);

  function automatic logic [5:0] ra(input int ch, input int off);
    return 6'(ch * 8 + off);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic rd16(input logic [5:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 6'd1, hi); d = {hi, lo};
  endtask

  task automatic pulse8();
    @(negedge clk); tick_div8 = 1; @(negedge clk); tick_div8 = 0;
  endtask

  task automatic pulse_fast();
    @(negedge clk); tick_fast = 1; @(negedge clk); tick_fast = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v; logic [7:0] b;
    rd16(ra(0,2), v); check("R1 counter", v, 0);
    rd16(ra(3,0), v); check("R1 reload", v, 0);
    rd(ra(2,4), b);   check("R1 mode", b, 0);
    rd(START_A, b);   check("R1 start", b, 0);
    check("R1 underflow", underflow, 0);
  endtask

  task automatic t_load_stopped();
    logic [15:0] v;
    wr(ra(1,0), 8'h34); wr(ra(1,1), 8'h12);
    rd16(ra(1,2), v); check("R2 stopped load", v, 16'h1234);
  endtask

  task automatic t_interval();
    logic [15:0] v;
    wr(ra(0,0), 8'd3); wr(ra(0,4), 8'h04); wr(START_A, 8'h01);
    @(negedge clk); tick_fast = 1; tick_div32 = 1; tick_slow = 1;
    repeat (5) step();
    tick_fast = 0; tick_div32 = 0; tick_slow = 0;
    rd16(ra(0,2), v); check("R3 other ticks ignored", v, 3);
    pulse8(); pulse8(); pulse8();
    rd16(ra(0,2), v); check("R3 decrement", v, 0);
    pulse8();
    check("R4 underflow high", underflow[0], 1);
    step();
    check("R4 underflow one cycle", underflow[0], 0);
    rd16(ra(0,2), v); check("R4 reload", v, 3);
  endtask

  task automatic t_running_reload();
    logic [15:0] v;
    wr(ra(0,0), 8'd5);
    rd16(ra(0,2), v); check("R5 counter untouched", v, 3);
    repeat (4) pulse8();
    rd16(ra(0,2), v); check("R5 new reload used", v, 5);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    wr(START_A, 8'h00);
    pulse8(); pulse8();
    rd16(ra(0,2), v); check("R11 stopped hold", v, 5);
  endtask

  task automatic t_event_pin();
    logic [15:0] v;
    wr(ra(1,4), 8'h01); wr(ra(1,0), 8'd10); wr(ra(1,1), 8'd0);
    wr(START_A, 8'h02);
    ext_in[1] = 1; step();
    rd16(ra(1,2), v); check("R6 rising counted", v, 9);
    ext_in[1] = 0; step();
    rd16(ra(1,2), v); check("R6 falling ignored", v, 9);
    wr(ra(1,4), 8'h11);
    ext_in[1] = 1; step();
    rd16(ra(1,2), v); check("R6 rising ignored", v, 9);
    ext_in[1] = 0; step();
    rd16(ra(1,2), v); check("R6 falling counted", v, 8);
  endtask

  task automatic t_idle_mode();
    logic [15:0] v;
    wr(ra(1,4), 8'h03);
    pulse_fast(); ext_in[1] = 1; step(); ext_in[1] = 0; step();
    rd16(ra(1,2), v); check("R12 reserved mode hold", v, 8);
  endtask

  task automatic t_cascade();
    logic [15:0] v;
    wr(START_A, 8'h00);
    wr(ra(5,4), 8'h00); wr(ra(5,0), 8'd1); wr(ra(5,1), 8'd0);
    wr(ra(3,4), 8'h09); wr(ra(3,0), 8'd7); wr(ra(3,1), 8'd0);
    wr(ra(0,4), 8'h09); wr(ra(0,0), 8'd4); wr(ra(0,1), 8'd0);
    wr(START_A, 8'h29);
    pulse_fast(); pulse_fast();
    check("R4 source underflow", underflow[5], 1);
    step();
    rd16(ra(3,2), v); check("R7 ch3 counts ch5", v, 6);
    rd16(ra(0,2), v); check("R7 ch0 ignores ch5", v, 4);
  endtask

  task automatic t_period();
    logic [15:0] v;
    wr(START_A, 8'h04); wr(ra(2,4), 8'h02);
    @(negedge clk); tick_fast = 1;
    ext_in[2] = 1; step();
    ext_in[2] = 0; repeat (4) step();
    ext_in[2] = 1; step();
    rd16(ra(2,0), v); check("R8 period capture", v, 4);
  endtask

  task automatic t_width();
    logic [15:0] v;
    ext_in[2] = 0; step(); step();
    wr(ra(2,4), 8'h12);
    ext_in[2] = 1; step(); step(); step();
    ext_in[2] = 0; step();
    rd16(ra(2,0), v); check("R9 width capture", v, 2);
  endtask

  task automatic t_overflow();
    logic [7:0] b;
    wr(START_A, 8'h10); wr(ra(4,4), 8'h02);
    rd(ra(4,4), b); check("R10 no early flag", b, 8'h02);
    repeat (65600) step();
    rd(ra(4,4), b); check("R10 flag set", b, 8'h22);
    wr(ra(4,4), 8'h02);
    rd(ra(4,4), b); check("R10 flag cleared", b, 8'h02);
    tick_fast = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load_stopped();
    t_interval();
    t_running_reload();
    t_stopped();
    t_event_pin();
    t_idle_mode();
    t_cascade();
    t_period();
    t_width();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule